// File: doc/BRIEF.md
# Single-Bit Signal Conditioner

This block cleans up and reshapes one logic-level signal before it feeds, or after it leaves, a stage of configurable logic. A 32-bit control word, held in a small register that is written and read through a plain register port, chooses the processing. The input can be passed straight through or resynchronised to the system clock. It can then be turned into one-clock pulses on chosen edges and run through a counter-based filter. That filter either rejects short glitches or stretches short high pulses. At the end it can be overridden to a fixed level by software and inverted.

Typical use is one instance per signal. Software writes the control word once, and the output is then a clean level or pulse in the clock domain that the next stage can use.

Top module: `sig_conditioner`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000_0004 (no forcing, all other processing off) and the output is low.
- R2: A write of the control word takes effect from the next clock. Read-back returns the written value with bits [11:9] and bit 15 forced to zero (write 0xFFFF_FFFF reads 0xFFFF_71FF).
- R3: With bit 0 set, the raw input reaches the output combinationally in the same cycle. Edge-detection bits [6:4] then have no effect.
- R4: With bit 0 clear, the input passes through a two-stage flip-flop synchroniser and appears two clocks later. Setting bit 7 selects a three-stage chain, which gives three clocks.
- R5: With bit 0 clear and bit 4 set, the signal becomes a one-clock high pulse per detected edge. Bit 6 enables rising edges and bit 5 enables falling edges; both may be set.
- R6: With bit 8 set and type bits [14:12] = 0, the stage output takes a new level only after the stage input has differed from it for N consecutive clocks, where N is bits [31:16]. Any control write restarts the count.
- R7: With bit 8 set and type = 1, every high input is stretched so that the output stays high for at least N clocks from its rising edge.
- R8: Type codes 2 to 7 pass the signal unchanged, and so does any type when bit 8 is clear.
- R9: Bits [2:1] = 0 force the output low and = 1 force it high, whatever the rest of the chain does. Values 2 and 3 leave the chain in control.
- R10: Bit 3 inverts the final output, after forcing (forced high with bit 3 set gives low).
- R11: A counter value N of zero acts as N = 1 for both filter types.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to condition |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word value to write |
| cfg_rd_data | output | 32 | Current control word, reserved bits zero |
| dout | output | 1 | Conditioned signal |

## Verification
The hardest states to reach from the ports are the counter boundaries of the extended filter. One case is an input that flips back exactly one clock before the glitch count completes. Another is a new high pulse that arrives while a stretch is still running, so the countdown reloads. The stimulus drives a shift-register pseudo-random bit stream whose run lengths spread across one to several clocks around a small count of 3 or 4. It also runs the stretch filter behind the rising-edge pulser, so that single-clock pulses reach it. A cycle-level reference model in the bench tracks the counters and predicts every output sample.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int CFG_W = 32;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [CNT_W-1:0] count;      // [31:16]
        logic             rsv_hi;     // [15]
        logic [2:0]       ftype;      // [14:12]
        logic [2:0]       rsv_lo;     // [11:9]
        logic             ext_en;     // [8]
        logic             deep_sync;  // [7]
        logic             rise_en;    // [6]
        logic             fall_en;    // [5]
        logic             edge_en;    // [4]
        logic             invert;     // [3]
        logic [1:0]       force_sel;  // [2:1]
        logic             bypass;     // [0]
    } cond_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0004;
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'hFFFF_71FF;

    localparam logic [2:0] FT_GLITCH  = 3'd0;
    localparam logic [2:0] FT_STRETCH = 3'd1;

    typedef enum logic [1:0] {
        FORCE_LOW   = 2'd0,
        FORCE_HIGH  = 2'd1,
        FORCE_NONE  = 2'd2,
        FORCE_NONE2 = 2'd3
    } force_e;

    function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/cond_cfg_reg.sv
module cond_cfg_reg
    import cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cond_cfg_t        cfg_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= cond_cfg_t'(CFG_RESET);
        else if (wr_en)
            cfg_o <= cond_cfg_t'(wr_data & CFG_WMASK);
    end

    // R2: written value lands on the next clock, masked
    a_r2_write_capture: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (CFG_W'(cfg_o) == ($past(wr_data) & CFG_WMASK)));

    // R2: no write, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_o));

endmodule

// File: rtl/cond_front.sv
module cond_front #(
    parameter int BASE_STAGES = 2,
    parameter int MAX_STAGES  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic bypass,
    input  logic deep,
    input  logic edge_en,
    input  logic rise_en,
    input  logic fall_en,
    output logic evt_o
);

    logic [MAX_STAGES-1:0] chain;
    logic                  tap;
    logic                  lvl;
    logic                  prev;
    logic                  rise;
    logic                  fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[MAX_STAGES-2:0], din};
            prev  <= lvl;
        end
    end

    generate
        if (MAX_STAGES > BASE_STAGES) begin : g_deep_tap
            assign tap = deep ? chain[MAX_STAGES-1] : chain[BASE_STAGES-1];
        end else begin : g_fixed_tap
            assign tap = chain[MAX_STAGES-1];
        end
    endgenerate

    assign lvl  = bypass ? din : tap;
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    always_comb begin
        if (!bypass && edge_en)
            evt_o = (rise & rise_en) | (fall & fall_en);
        else
            evt_o = lvl;
    end

    // R5: with only rising edges enabled, a pulse never lasts two clocks
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (!bypass && edge_en && rise_en && !fall_en && evt_o)
        |=> (!evt_o || !$stable({bypass, deep, edge_en, rise_en, fall_en})));

endmodule

// File: rtl/cond_ext_filter.sv
module cond_ext_filter
    import cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             x,
    input  logic             ext_en,
    input  logic [2:0]       ftype,
    input  logic [CNT_W-1:0] count,
    output logic             y
);

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;
    logic             fq;
    logic             glitch_mode;
    logic             stretch_mode;

    assign lim          = eff_limit(count);
    assign glitch_mode  = ext_en && (ftype == FT_GLITCH);
    assign stretch_mode = ext_en && (ftype == FT_STRETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            fq  <= 1'b0;
            cnt <= '0;
        end else if (clr) begin
            fq  <= x;
            cnt <= '0;
        end else if (glitch_mode) begin
            if (x == fq) begin
                cnt <= '0;
            end else if (cnt >= lim - 1'b1) begin
                fq  <= x;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (stretch_mode) begin
            if (x)
                cnt <= lim - 1'b1;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end else begin
            fq  <= x;
            cnt <= '0;
        end
    end

    always_comb begin
        if (glitch_mode)
            y = fq;
        else if (stretch_mode)
            y = x | (cnt != '0);
        else
            y = x;
    end

    // R6: a change shorter than the limit leaves the level alone
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && glitch_mode && (x != fq) && (cnt < lim - 1'b1)) |=> $stable(fq));

    // R6: once the count is complete the level follows the input
    a_r6_settle: assert property (@(posedge clk) disable iff (rst)
        (!clr && glitch_mode && (x != fq) && (cnt >= lim - 1'b1)) |=> (fq == $past(x)));

    // R7: a high input keeps the stretched output high on the next clock
    a_r7_stretch: assert property (@(posedge clk) disable iff (rst)
        (!clr && stretch_mode && x && (lim >= CNT_W'(2))) |=> y);

endmodule

// File: rtl/sig_conditioner.sv
module sig_conditioner
    import cond_pkg::*;
#(
    parameter int BASE_STAGES = 2,
    parameter int MAX_STAGES  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    output logic             dout
);

    cond_cfg_t cfg_q;
    logic      evt;
    logic      filt;
    logic      forced;

    cond_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg_q)
    );

    cond_front #(
        .BASE_STAGES (BASE_STAGES),
        .MAX_STAGES  (MAX_STAGES)
    ) u_front (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .bypass  (cfg_q.bypass),
        .deep    (cfg_q.deep_sync),
        .edge_en (cfg_q.edge_en),
        .rise_en (cfg_q.rise_en),
        .fall_en (cfg_q.fall_en),
        .evt_o   (evt)
    );

    cond_ext_filter u_filt (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_wr_en),
        .x      (evt),
        .ext_en (cfg_q.ext_en),
        .ftype  (cfg_q.ftype),
        .count  (cfg_q.count),
        .y      (filt)
    );

    always_comb begin
        case (force_e'(cfg_q.force_sel))
            FORCE_LOW:  forced = 1'b0;
            FORCE_HIGH: forced = 1'b1;
            default:    forced = filt;
        endcase
    end

    assign dout        = forced ^ cfg_q.invert;
    assign cfg_rd_data = cfg_q;

    // R9: forcing overrides every upstream stage
    a_r9_force_low: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[2:1] == 2'd0 && !cfg_rd_data[3]) |-> !dout);
    a_r9_force_high: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[2:1] == 2'd1 && !cfg_rd_data[3]) |-> dout);

    // R10: inversion sits after forcing
    a_r10_invert_forced: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[2:1] == 2'd1 && cfg_rd_data[3]) |-> !dout);

    // R3: raw path with nothing else enabled
    a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[0] && !cfg_rd_data[8] && cfg_rd_data[2] && !cfg_rd_data[3])
        |-> (dout == din));

endmodule

// File: tb/sig_conditioner_tb_top.sv
module sig_conditioner_tb_top;

    localparam logic [31:0] MASK = 32'hFFFF_71FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b0;
    logic        we  = 1'b0;
    logic [31:0] wd  = '0;
    logic [31:0] rd;
    logic        dout;

    always #10 clk = ~clk;

    sig_conditioner dut_i (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .cfg_wr_en   (we),
        .cfg_wr_data (wd),
        .cfg_rd_data (rd),
        .dout        (dout)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    n_chk  = 0;
    int    n_fail = 0;

    // reference model state
    logic [31:0] m_cfg = 32'h4;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0, m_prev = 0, m_fq = 0;
    logic [15:0] m_cnt = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: value=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_x0(input logic d);
        if (m_cfg[0]) return d;
        return m_cfg[7] ? m_s3 : m_s2;
    endfunction

    function automatic logic m_x1(input logic x0);
        if (!m_cfg[0] && m_cfg[4])
            return (x0 & ~m_prev & m_cfg[6]) | (~x0 & m_prev & m_cfg[5]);
        return x0;
    endfunction

    function automatic logic m_x2(input logic x1);
        if (m_cfg[8] && m_cfg[14:12] == 3'd0) return m_fq;
        if (m_cfg[8] && m_cfg[14:12] == 3'd1) return x1 | (m_cnt != 0);
        return x1;
    endfunction

    function automatic logic m_out(input logic x2);
        logic f;
        case (m_cfg[2:1])
            2'd0:    f = 1'b0;
            2'd1:    f = 1'b1;
            default: f = x2;
        endcase
        return f ^ m_cfg[3];
    endfunction

    // driver: apply one cycle of stimulus, push expected sample, advance model
    task automatic step(input logic d, input logic w, input logic [31:0] data, input string tag);
        logic x0, x1, x2, nfq;
        logic [15:0] lim, ncnt;
        @(negedge clk);
        din = d;
        we  = w;
        wd  = data;
        x0 = m_x0(d);
        x1 = m_x1(x0);
        x2 = m_x2(x1);
        sb.push_back('{m_out(x2), tag});
        lim  = (m_cfg[31:16] == 0) ? 16'd1 : m_cfg[31:16];
        nfq  = m_fq;
        ncnt = m_cnt;
        if (w) begin
            ncnt = 0;
            nfq  = x1;
        end else if (m_cfg[8] && m_cfg[14:12] == 3'd0) begin
            if (x1 == m_fq) ncnt = 0;
            else if (m_cnt >= lim - 1) begin nfq = x1; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end else if (m_cfg[8] && m_cfg[14:12] == 3'd1) begin
            if (x1) ncnt = lim - 1;
            else if (m_cnt != 0) ncnt = m_cnt - 1;
        end else begin
            ncnt = 0;
            nfq  = x1;
        end
        m_s3 = m_s2;
        m_s2 = m_s1;
        m_s1 = d;
        m_prev = x0;
        m_fq  = nfq;
        m_cnt = ncnt;
        if (w) m_cfg = data & MASK;
    endtask

    task automatic run_cfg(input logic [31:0] cfg, input int n, input string tag);
        step(1'b0, 1'b1, cfg, tag);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], 1'b0, '0, tag);
        end
    endtask

    // monitor: compare each produced sample against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(dout, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        check32(rd, 32'h0000_0004, "R1 reset word");
        check(dout, 1'b0, "R1 reset output");

        // R2: masked read-back
        step(1'b0, 1'b1, 32'hFFFF_FFFF, "R2");
        step(1'b0, 1'b0, '0, "R2");
        #5;
        check32(rd, 32'hFFFF_71FF, "R2 readback");

        run_cfg(32'h0000_0004, 40, "R4 two-stage sync");
        run_cfg(32'h0000_0084, 40, "R4 three-stage sync");
        run_cfg(32'h0000_0005, 30, "R3 bypass");
        run_cfg(32'h0000_0075, 30, "R3 bypass ignores edges");
        run_cfg(32'h0000_0054, 40, "R5 rising edge");
        run_cfg(32'h0000_0034, 40, "R5 falling edge");
        run_cfg(32'h0000_0074, 40, "R5 both edges");
        run_cfg(32'h0003_0104, 80, "R6 glitch N=3");
        run_cfg(32'h0004_1154, 80, "R7 stretch N=4 rising pulses");
        run_cfg(32'h0003_1104, 60, "R7 stretch N=3 levels");
        run_cfg(32'h0003_5104, 40, "R8 unused type");
        run_cfg(32'h0003_0004, 30, "R8 filter disabled");
        run_cfg(32'h0000_0104, 40, "R11 glitch N=0");
        run_cfg(32'h0000_1154, 40, "R11 stretch N=0");
        run_cfg(32'h0003_0150, 30, "R9 force low");
        run_cfg(32'h0003_0152, 30, "R9 force high");
        run_cfg(32'h0000_0006, 30, "R9 code 3 no force");
        run_cfg(32'h0000_000C, 30, "R10 invert");
        run_cfg(32'h0000_000A, 20, "R10 forced high inverted");
        // R6: write in mid-count restarts the glitch counter
        run_cfg(32'h0003_0104, 20, "R6 restart after write");

        while (sb.size() > 0) @(negedge clk);
        #10;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule